// File: doc/BRIEF.md
# Configuration Unlock Sequencer for an Index/Data Port Pair

This block sits behind a legacy I/O bus and owns a two-address window: an index port at 0x4E and a data port at 0x4F. Software writes a register number to the index port and then a value to the data port. Configuration writes are accepted only after a two-byte unlock key has reached the index port. A separate two-byte lock key closes the window again. Each byte of either key has its own retry and fall-back transition, so software can resend a key byte without starting over.

Index writes always update the stored index, whatever the sequencer state. An index read returns the stored index. A data read returns 0xFF. An accepted data write produces a one-cycle strobe that carries the index and the data byte to the register file behind the block, which lies outside this design. The whole window responds only while the enable input `pair_en` is high. While it is low, the block leaves bus cycles unclaimed and changes no state.

The sequencer has four states. LOCKED (0) is the reset state. ARMED (1) is reached after the first unlock byte. OPEN (2) means configuration is active. CLOSING (3) is reached after the first lock byte. Every transition is triggered by an index-port write:
- LOCKED: 0x80 moves to ARMED. Any other value stays in LOCKED.
- ARMED: 0x86 moves to OPEN. 0x80 stays in ARMED. Any other value falls back to LOCKED.
- OPEN: 0x68 moves to CLOSING. Any other value stays in OPEN.
- CLOSING: 0x08 moves to LOCKED. 0x68 stays in CLOSING. Any other value falls back to OPEN.

Top module: `cfg_key_unlock`

## Requirements
- R1: After reset, the state is LOCKED, `cfg_active` is 0, and an index-port read returns 0x00.
- R2: A bus cycle is claimed (`io_claim`=1, combinational in the same cycle as the strobe) only when `io_addr` is exactly 0x004E or 0x004F and `pair_en`=1. Any other address reads as 0x00 and is not claimed.
- R3: In LOCKED, an index write of 0x80 goes to ARMED. Any other value stays in LOCKED.
- R4: In ARMED, 0x86 goes to OPEN, 0x80 stays in ARMED, and any other value returns to LOCKED. `cfg_active` is 1 exactly in OPEN and CLOSING, one cycle after the write that reaches them.
- R5: In OPEN, 0x68 goes to CLOSING. Any other value stays in OPEN.
- R6: In CLOSING, 0x08 goes to LOCKED, 0x68 stays in CLOSING, and any other value returns to OPEN.
- R7: Every index write stores its byte as the index, in any state. An index-port read returns the stored index combinationally.
- R8: A data-port read always returns 0xFF.
- R9: A data write in LOCKED or ARMED is dropped, with no strobe. A data write in OPEN or CLOSING raises `cfg_wr_stb` for one cycle, starting on the next clock edge, with `cfg_wr_index` equal to the stored index and `cfg_wr_data` equal to the written byte.
- R10: While `pair_en`=0, writes to either port change neither the state nor the index and raise no strobe. Reads return 0x00 and are not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| pair_en | input | 1 | Enable for the index/data port pair |
| io_rdata | output | 8 | Read data, valid in the read cycle |
| io_claim | output | 1 | High when the current access hits the enabled pair |
| cfg_wr_stb | output | 1 | One-cycle strobe for an accepted configuration write |
| cfg_wr_index | output | 8 | Index that belongs to the strobed write |
| cfg_wr_data | output | 8 | Data byte that belongs to the strobed write |
| cfg_active | output | 1 | High while the sequencer is in OPEN or CLOSING |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data, ports 0x4E/0x4F and the standard key bytes. With these values the stimulus can be written directly in the literal byte values of the key protocol. The vector table walks every state through its key byte, its retry byte and its fall-back byte. Because `cfg_active` alone does not separate LOCKED from ARMED, or OPEN from CLOSING, the table follows ambiguous steps with a probe byte whose outcome tells the two states apart. Directed tests cover the disabled window, near-miss addresses, and a reset taken while the window is open.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED  = 2'd0,
        KS_ARMED   = 2'd1,
        KS_OPEN    = 2'd2,
        KS_CLOSING = 2'd3
    } key_state_t;

endpackage

// File: rtl/cfgkey_decode.sv
module cfgkey_decode #(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h004E,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h004F
) (
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              pair_en,
    output logic              idx_wr,
    output logic              idx_rd,
    output logic              dat_wr,
    output logic              dat_rd,
    output logic              claim
);

    logic hit_idx;
    logic hit_dat;
    logic rd_only;

    always_comb begin
        hit_idx = pair_en && (io_addr == INDEX_PORT);
        hit_dat = pair_en && (io_addr == DATA_PORT);
        // a write takes precedence over a simultaneous read
        rd_only = io_rd && !io_wr;
        idx_wr  = io_wr && hit_idx;
        dat_wr  = io_wr && hit_dat;
        idx_rd  = rd_only && hit_idx;
        dat_rd  = rd_only && hit_dat;
        claim   = (io_wr || io_rd) && (hit_idx || hit_dat);
    end

endmodule

// File: rtl/cfgkey_fsm.sv
module cfgkey_fsm
    import cfgkey_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] OPEN_K1 = 8'h80,
    parameter logic [DATA_W-1:0] OPEN_K2 = 8'h86,
    parameter logic [DATA_W-1:0] SHUT_K1 = 8'h68,
    parameter logic [DATA_W-1:0] SHUT_K2 = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] wdata,
    output key_state_t        state,
    output logic              cfg_active
);

    key_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (idx_wr) begin
            unique case (state)
                KS_LOCKED:  state_nx = (wdata == OPEN_K1) ? KS_ARMED : KS_LOCKED;
                KS_ARMED:   state_nx = (wdata == OPEN_K2) ? KS_OPEN :
                                       (wdata == OPEN_K1) ? KS_ARMED : KS_LOCKED;
                KS_OPEN:    state_nx = (wdata == SHUT_K1) ? KS_CLOSING : KS_OPEN;
                KS_CLOSING: state_nx = (wdata == SHUT_K2) ? KS_LOCKED :
                                       (wdata == SHUT_K1) ? KS_CLOSING : KS_OPEN;
                default:    state_nx = KS_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            KS_OPEN, KS_CLOSING: cfg_active = 1'b1;
            default:             cfg_active = 1'b0;
        endcase
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_LOCKED && idx_wr && wdata != OPEN_K1) |=> (state == KS_LOCKED));
    // R4
    open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_ARMED && idx_wr && wdata == OPEN_K2) |=> cfg_active);
    // R5
    open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_OPEN && idx_wr && wdata != SHUT_K1) |=> (state == KS_OPEN));
    // R6
    close_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_CLOSING && idx_wr && wdata == SHUT_K2) |=> !cfg_active);
    // R10
    state_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(state));

endmodule

// File: rtl/cfgkey_port_regs.sv
module cfgkey_port_regs #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] DATA_RD = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              idx_rd,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_active,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_index,
    output logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] index_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      index_q <= '0;
        else if (idx_wr) index_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb   <= 1'b0;
            wr_index <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= dat_wr && cfg_active;
            if (dat_wr && cfg_active) begin
                wr_index <= index_q;
                wr_data  <= wdata;
            end
        end
    end

    always_comb begin
        if (idx_rd)      rdata = index_q;
        else if (dat_rd) rdata = DATA_RD;
        else             rdata = '0;
    end

    // R9
    stb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(cfg_active));
    // R7
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(index_q));

endmodule

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
    import cfgkey_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h004E,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h004F,
    parameter logic [DATA_W-1:0] OPEN_K1    = 8'h80,
    parameter logic [DATA_W-1:0] OPEN_K2    = 8'h86,
    parameter logic [DATA_W-1:0] SHUT_K1    = 8'h68,
    parameter logic [DATA_W-1:0] SHUT_K2    = 8'h08,
    parameter logic [DATA_W-1:0] DATA_RD    = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              pair_en,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_claim,
    output logic              cfg_wr_stb,
    output logic [DATA_W-1:0] cfg_wr_index,
    output logic [DATA_W-1:0] cfg_wr_data,
    output logic              cfg_active
);

    logic       idx_wr;
    logic       idx_rd;
    logic       dat_wr;
    logic       dat_rd;
    key_state_t state;

    cfgkey_decode #(
        .ADDR_W     (ADDR_W),
        .INDEX_PORT (INDEX_PORT),
        .DATA_PORT  (DATA_PORT)
    ) u_decode (
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .pair_en (pair_en),
        .idx_wr  (idx_wr),
        .idx_rd  (idx_rd),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd),
        .claim   (io_claim)
    );

    cfgkey_fsm #(
        .DATA_W  (DATA_W),
        .OPEN_K1 (OPEN_K1),
        .OPEN_K2 (OPEN_K2),
        .SHUT_K1 (SHUT_K1),
        .SHUT_K2 (SHUT_K2)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .wdata      (io_wdata),
        .state      (state),
        .cfg_active (cfg_active)
    );

    cfgkey_port_regs #(
        .DATA_W  (DATA_W),
        .DATA_RD (DATA_RD)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .idx_rd     (idx_rd),
        .dat_wr     (dat_wr),
        .dat_rd     (dat_rd),
        .wdata      (io_wdata),
        .cfg_active (cfg_active),
        .rdata      (io_rdata),
        .wr_stb     (cfg_wr_stb),
        .wr_index   (cfg_wr_index),
        .wr_data    (cfg_wr_data)
    );

    // R2
    claim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_en |-> !io_claim);
    // R8
    data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && pair_en && io_addr == DATA_PORT) |-> (io_rdata == DATA_RD));
    // R9
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DATA_PORT && (state == KS_LOCKED || state == KS_ARMED))
            |=> !cfg_wr_stb);
    // R1
    active_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_active |-> (state == KS_OPEN || state == KS_CLOSING));

endmodule

// File: tb/test_cfg_key_unlock.sv
`timescale 1ns/1ps
module test_cfg_key_unlock;

    localparam logic [15:0] IDX = 16'h004E;
    localparam logic [15:0] DAT = 16'h004F;
    localparam int NV = 22;
    // {req, op(0 index wr / 1 data wr), byte, expected cfg_active, expected strobe}
    localparam logic [23:0] VEC [0:NV-1] = '{
        24'h3_0_12_0_0, 24'h9_1_55_0_0, 24'h3_0_80_0_0, 24'h9_1_44_0_0,
        24'h4_0_80_0_0, 24'h4_0_86_1_0, 24'h9_1_A5_1_1, 24'h5_0_33_1_0,
        24'h9_1_5A_1_1, 24'h5_0_68_1_0, 24'h6_0_68_1_0, 24'h6_0_07_1_0,
        24'h5_0_08_1_0, 24'h5_0_68_1_0, 24'h9_1_C3_1_1, 24'h6_0_08_0_0,
        24'h9_1_11_0_0, 24'h3_0_80_0_0, 24'h4_0_10_0_0, 24'h3_0_86_0_0,
        24'h3_0_80_0_0, 24'h4_0_86_1_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        pair_en = 1'b1;
    logic [7:0]  io_rdata;
    logic        io_claim;
    logic        cfg_wr_stb;
    logic [7:0]  cfg_wr_index;
    logic [7:0]  cfg_wr_data;
    logic        cfg_active;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_idx = 8'h00;
    logic [7:0] rd_v;
    logic       cl_v;

    always #4 clk = ~clk;

    cfg_key_unlock i_cfg_key_unlock (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .pair_en(pair_en),
        .io_rdata(io_rdata), .io_claim(io_claim), .cfg_wr_stb(cfg_wr_stb),
        .cfg_wr_index(cfg_wr_index), .cfg_wr_data(cfg_wr_data),
        .cfg_active(cfg_active)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic c);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        v = io_rdata; c = io_claim;
        @(negedge clk);
        io_rd = 1'b0; io_addr = '0;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "cfg_active after reset", cfg_active, 0);
        chk("R1", "strobe after reset", cfg_wr_stb, 0);
        rd(IDX, rd_v, cl_v);
        chk("R1", "index after reset", rd_v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            string req;
            logic op;
            logic [7:0] b;
            req = $sformatf("R%0d", VEC[i][23:20]);
            op  = VEC[i][16];
            b   = VEC[i][15:8];
            if (op) wr(DAT, b);
            else begin wr(IDX, b); exp_idx = b; end
            chk(req, $sformatf("vec %0d cfg_active", i), cfg_active, VEC[i][4]);
            chk(req, $sformatf("vec %0d strobe", i), cfg_wr_stb, VEC[i][0]);
            if (VEC[i][0]) begin
                chk("R9", "strobe index", cfg_wr_index, exp_idx);
                chk("R9", "strobe data", cfg_wr_data, b);
                @(negedge clk);
                chk("R9", "strobe width", cfg_wr_stb, 0);
            end
            if (!op) begin
                rd(IDX, rd_v, cl_v);
                chk("R7", "index readback", rd_v, exp_idx);
            end
        end

        // state OPEN, index 0x86
        rd(IDX, rd_v, cl_v);
        chk("R7", "index read claim", cl_v, 1);
        rd(DAT, rd_v, cl_v);
        chk("R8", "data read open", rd_v, 8'hFF);
        chk("R2", "data read claim", cl_v, 1);
        rd(16'h004D, rd_v, cl_v);
        chk("R2", "near address claim", cl_v, 0);
        chk("R2", "near address data", rd_v, 8'h00);
        rd(16'h014E, rd_v, cl_v);
        chk("R2", "high-bit alias claim", cl_v, 0);

        // R10 disabled window
        pair_en = 1'b0;
        wr(IDX, 8'h68);
        wr(IDX, 8'h08);
        chk("R10", "cfg_active while disabled", cfg_active, 1);
        wr(DAT, 8'h77);
        chk("R10", "no strobe while disabled", cfg_wr_stb, 0);
        rd(IDX, rd_v, cl_v);
        chk("R10", "disabled read claim", cl_v, 0);
        chk("R10", "disabled read data", rd_v, 8'h00);
        rd(DAT, rd_v, cl_v);
        chk("R10", "disabled data read", rd_v, 8'h00);
        pair_en = 1'b1;
        rd(IDX, rd_v, cl_v);
        chk("R10", "index kept", rd_v, 8'h86);
        wr(IDX, 8'h08);
        chk("R10", "still OPEN not CLOSING", cfg_active, 1);

        // R1 reset while open
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "cfg_active in reset", cfg_active, 0);
        rst_n = 1'b1;
        rd(IDX, rd_v, cl_v);
        chk("R1", "index cleared", rd_v, 8'h00);
        wr(DAT, 8'h99);
        chk("R1", "locked after reset", cfg_wr_stb, 0);
        rd(DAT, rd_v, cl_v);
        chk("R8", "data read locked", rd_v, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule